// File: doc/BRIEF.md
# Multichannel Block-Move DMA Engine

This block copies blocks of 32-bit words from one place in a shared memory to another. It has several independent channels. Each channel keeps its own source pointer, destination pointer, remaining word count, stride and mode flags. Software programs a channel through a small write port and then arms it. Any armed channel makes the engine request the system bus. Once the bus is granted, the engine issues one memory read per clock. Each word read is written to the destination two cycles later.

The bus owner can take the grant away at any clock. The engine then stops issuing reads and lets go of its current channel. The pointers and count stay in that channel's registers, so when the grant returns the copy continues from the exact word where it stopped. Channel selection happens only while the engine is not bound to a channel, and the lowest-numbered armed channel wins. A channel armed during a revocation can therefore take over from a lower-priority one. Each channel can optionally raise a one-cycle completion pulse.

Top module: `blk_dma`

## Requirements
- R1: While the synchronous reset is held, bus_req, rd_en, wr_en and every irq bit are 0.
- R2: cfg_sel selects the register being written: 0 source, 1 destination, 2 word count, 3 stride, 4 control. Control bits are: bit0 start, bit1 completion pulse enable, bit2 source uses stride, bit3 destination uses stride, bit4 source steps downward, bit5 destination steps downward. Programming a channel without a control write that has bit0 set causes no bus request and no read.
- R3: bus_req is 1 in the cycle after an edge at which any channel held pending words, and 0 in the cycle after an edge at which none did. rd_en is never 1 while bus_req is 0.
- R4: A read (rd_en high in the following cycle, rd_addr = current source pointer) is issued only at an edge where bus_gnt and bus_req are both 1 and a channel is bound. While the grant stays high, one word is read per cycle.
- R5: Memory returns the read word on mem_rd_data in the cycle after rd_en. The engine drives wr_en exactly two cycles after rd_en, with that word as wr_data and the destination pointer held at issue time as wr_addr.
- R6: After each word, each pointer moves by 1, or by the stride register if its stride bit is set. It moves downward when its down bit is set. Pointers wrap modulo 2^AW.
- R7: If bus_gnt is 0 at an edge, no read is issued at that edge and the engine unbinds. The request stays asserted, and when the grant returns the channel continues from its saved pointers with its remaining count.
- R8: An unbound engine binds, at the next edge, to the lowest-numbered channel with pending words. A bound channel keeps the engine until its last word is read or the grant is lost.
- R9: When bit1 was set, irq[ch] pulses for exactly one cycle, in the same cycle as the final write of that channel's block. No pulse occurs otherwise, and at most one irq bit is high at a time.
- R10: Register writes to a channel with pending words are ignored. A start with a word count of 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel being written |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | RW | Register write data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DW | Memory write data |
| irq | output | NUM_CH | Per-channel completion pulse |

## Verification
The hardest case to reach from the ports is a grant that drops while words are still in the read-to-write pipeline, combined with a higher-priority channel being armed during that same gap. The resumed stream must then switch channels and later come back to the interrupted block without losing or repeating a word. The stimulus reaches this state in two ways. In one test it holds the grant low while it programs a second channel in the middle of a long copy. In another it drives the grant with an irregular on/off pattern across a 20-word block. Every clock, the outputs are compared with a behavioural model, and afterwards the destination memory is checked word by word.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [2:0] {
    SEL_SRC    = 3'd0,
    SEL_DST    = 3'd1,
    SEL_CNT    = 3'd2,
    SEL_STRIDE = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  localparam int CB_GO   = 0;
  localparam int CB_IRQ  = 1;
  localparam int CB_SSTR = 2;
  localparam int CB_DSTR = 3;
  localparam int CB_SDN  = 4;
  localparam int CB_DDN  = 5;
endpackage

// File: rtl/dmx_chan.sv
module dmx_chan #(
  parameter int AW   = 16,
  parameter int CNTW = 16,
  parameter int RW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [RW-1:0]   wr_data,
  input  logic            adv,
  output logic [AW-1:0]   src_q,
  output logic [AW-1:0]   dst_q,
  output logic [CNTW-1:0] cnt_q,
  output logic            busy_q,
  output logic            irq_en_q
);
  import dmx_pkg::*;

  logic [AW-1:0] stride_q;
  logic [AW-1:0] src_delta;
  logic [AW-1:0] dst_delta;
  logic          s_str, d_str, s_dn, d_dn;

  assign src_delta = s_str ? stride_q : AW'(1);
  assign dst_delta = d_str ? stride_q : AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      stride_q <= '0;
      busy_q   <= 1'b0;
      irq_en_q <= 1'b0;
      s_str    <= 1'b0;
      d_str    <= 1'b0;
      s_dn     <= 1'b0;
      d_dn     <= 1'b0;
    end else if (adv && busy_q) begin
      src_q <= s_dn ? src_q - src_delta : src_q + src_delta;
      dst_q <= d_dn ? dst_q - dst_delta : dst_q + dst_delta;
      cnt_q <= cnt_q - CNTW'(1);
      if (cnt_q == CNTW'(1)) busy_q <= 1'b0;
    end else if (wr_en && !busy_q) begin
      case (wr_sel)
        SEL_SRC:    src_q    <= wr_data[AW-1:0];
        SEL_DST:    dst_q    <= wr_data[AW-1:0];
        SEL_CNT:    cnt_q    <= wr_data[CNTW-1:0];
        SEL_STRIDE: stride_q <= wr_data[AW-1:0];
        SEL_CTRL: begin
          irq_en_q <= wr_data[CB_IRQ];
          s_str    <= wr_data[CB_SSTR];
          d_str    <= wr_data[CB_DSTR];
          s_dn     <= wr_data[CB_SDN];
          d_dn     <= wr_data[CB_DDN];
          busy_q   <= wr_data[CB_GO] && (cnt_q != '0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dmx_prio.sv
module dmx_prio #(
  parameter int N   = 4,
  parameter int CHW = 2
) (
  input  logic [N-1:0]   req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/dmx_pipe.sv
module dmx_pipe #(
  parameter int N    = 4,
  parameter int CHW  = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    busy,
  input  logic [N-1:0]    irq_en,
  input  logic            pick_any,
  input  logic [CHW-1:0]  pick_idx,
  input  logic [AW-1:0]   cur_src,
  input  logic [AW-1:0]   cur_dst,
  input  logic [CNTW-1:0] cur_cnt,
  input  logic            bus_gnt,
  input  logic            bus_req,
  input  logic [DW-1:0]   mem_rd_data,
  output logic [CHW-1:0]  act_ch,
  output logic            adv,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [N-1:0]    irq
);
  logic           act_vld;
  logic           last_word;
  logic           s1_vld, s2_vld, s1_fin, s2_fin;
  logic [AW-1:0]  s1_dst, s2_dst;
  logic [CHW-1:0] s1_ch, s2_ch;

  assign adv       = act_vld && bus_gnt && bus_req && busy[act_ch];
  assign last_word = (cur_cnt == CNTW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_vld <= 1'b0;
      act_ch  <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      s1_vld  <= 1'b0;
      s1_fin  <= 1'b0;
      s1_dst  <= '0;
      s1_ch   <= '0;
      s2_vld  <= 1'b0;
      s2_fin  <= 1'b0;
      s2_dst  <= '0;
      s2_ch   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      irq     <= '0;
    end else begin
      if (act_vld) begin
        if (!bus_gnt || (adv && last_word)) act_vld <= 1'b0;
      end else if (pick_any) begin
        act_vld <= 1'b1;
        act_ch  <= pick_idx;
      end
      rd_en <= adv;
      if (adv) rd_addr <= cur_src;
      s1_vld  <= adv;
      s1_fin  <= adv && last_word && irq_en[act_ch];
      s1_dst  <= cur_dst;
      s1_ch   <= act_ch;
      s2_vld  <= s1_vld;
      s2_fin  <= s1_fin;
      s2_dst  <= s1_dst;
      s2_ch   <= s1_ch;
      wr_en   <= s2_vld;
      wr_addr <= s2_dst;
      wr_data <= mem_rd_data;
      irq     <= s2_fin ? (N'(1) << s2_ch) : '0;
    end
  end
endmodule

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int CNTW   = 16,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RW    = (AW > CNTW) ? AW : CNTW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [RW-1:0]     cfg_wdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [NUM_CH-1:0] irq
);
  logic [AW-1:0]     src_a [NUM_CH];
  logic [AW-1:0]     dst_a [NUM_CH];
  logic [CNTW-1:0]   cnt_a [NUM_CH];
  logic [NUM_CH-1:0] busy_v;
  logic [NUM_CH-1:0] ien_v;
  logic              adv;
  logic              pick_any;
  logic [CHW-1:0]    pick_idx;
  logic [CHW-1:0]    act_ch;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmx_chan #(.AW(AW), .CNTW(CNTW), .RW(RW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we && (cfg_ch == CHW'(g))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .adv      (adv && (act_ch == CHW'(g))),
      .src_q    (src_a[g]),
      .dst_q    (dst_a[g]),
      .cnt_q    (cnt_a[g]),
      .busy_q   (busy_v[g]),
      .irq_en_q (ien_v[g])
    );
  end

  dmx_prio #(.N(NUM_CH), .CHW(CHW)) u_prio (
    .req (busy_v),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_req <= 1'b0;
    else     bus_req <= |busy_v;
  end

  dmx_pipe #(.N(NUM_CH), .CHW(CHW), .AW(AW), .DW(DW), .CNTW(CNTW)) u_pipe (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy_v),
    .irq_en      (ien_v),
    .pick_any    (pick_any),
    .pick_idx    (pick_idx),
    .cur_src     (src_a[act_ch]),
    .cur_dst     (dst_a[act_ch]),
    .cur_cnt     (cnt_a[act_ch]),
    .bus_gnt     (bus_gnt),
    .bus_req     (bus_req),
    .mem_rd_data (mem_rd_data),
    .act_ch      (act_ch),
    .adv         (adv),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .irq         (irq)
  );
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_req,
  input logic         bus_gnt,
  input logic         rd_en,
  input logic         wr_en,
  input logic [N-1:0] irq
);
  AST_RD_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ($past(bus_gnt) && $past(bus_req))); // R4
  AST_RD_UNDER_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> bus_req); // R3
  AST_WR_TRAILS_RD: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 wr_en); // R5
  AST_WR_HAS_RD: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en, 2)); // R5
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq)); // R9
  AST_IRQ_ON_WR: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> wr_en); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|irq) |=> !(|irq)); // R9
endmodule

bind blk_dma blk_dma_chk #(.N(NUM_CH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_req (bus_req),
  .bus_gnt (bus_gnt),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .irq     (irq)
);

// File: tb/blk_dma_tb.sv
module blk_dma_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  blk_dma u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .rd_en(rd_en),
    .rd_addr(rd_addr), .mem_rd_data(mem_rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  // memory model: read data one cycle after rd_en
  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (rd_en) mem_rd_data <= mem[rd_addr[9:0]];
    if (wr_en) mem[wr_addr[9:0]] <= wr_data;
  end

  function automatic logic [31:0] pat(input int a);
    return 32'hC0DE0000 ^ (a * 40503);
  endfunction

  // behavioural reference model
  typedef struct { bit v; logic [15:0] d; bit f; int ch; } ent_t;
  ent_t        pq[$];
  logic [15:0] m_src[4], m_dst[4], m_cnt[4], m_str[4];
  bit          m_ss[4], m_ds[4], m_sd[4], m_dd[4], m_ie[4], m_busy[4];
  bit          m_act;
  int          m_ch;
  bit          e_req, e_rd_en, e_wr_en;
  logic [15:0] e_rd_addr, e_wr_addr;
  logic [31:0] e_wr_data;
  logic [3:0]  e_irq;
  ent_t        head, nw;
  bit          iss, anyb, ob;
  int          pk, c;
  logic [15:0] dl;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_str[i] = 0;
        m_ss[i] = 0; m_ds[i] = 0; m_sd[i] = 0; m_dd[i] = 0; m_ie[i] = 0; m_busy[i] = 0;
      end
      m_act = 0; m_ch = 0;
      pq.delete();
      nw = '{v: 0, d: 0, f: 0, ch: 0};
      pq.push_back(nw); pq.push_back(nw);
      e_req = 0; e_rd_en = 0; e_wr_en = 0; e_irq = 0;
      e_rd_addr = 0; e_wr_addr = 0; e_wr_data = 0;
    end else begin
      anyb = 0; pk = 0;
      for (int i = 3; i >= 0; i--) if (m_busy[i]) begin anyb = 1; pk = i; end
      ob = m_busy[cfg_ch];
      iss = m_act && bus_gnt && e_req && m_busy[m_ch];
      head = pq.pop_front();
      e_wr_en = head.v;
      e_wr_addr = head.d;
      e_wr_data = mem_rd_data;
      e_irq = head.f ? (4'b1 << head.ch) : 4'b0;
      nw.v = iss; nw.d = m_dst[m_ch]; nw.ch = m_ch;
      nw.f = iss && (m_cnt[m_ch] == 1) && m_ie[m_ch];
      pq.push_back(nw);
      e_rd_en = iss;
      if (iss) e_rd_addr = m_src[m_ch];
      e_req = anyb;
      if (m_act) begin
        if (!bus_gnt || (iss && m_cnt[m_ch] == 1)) m_act = 0;
      end else if (anyb) begin
        m_act = 1; m_ch = pk;
      end
      if (iss) begin
        c = nw.ch;
        dl = m_ss[c] ? m_str[c] : 16'd1;
        m_src[c] = m_sd[c] ? m_src[c] - dl : m_src[c] + dl;
        dl = m_ds[c] ? m_str[c] : 16'd1;
        m_dst[c] = m_dd[c] ? m_dst[c] - dl : m_dst[c] + dl;
        m_cnt[c] = m_cnt[c] - 1;
        if (m_cnt[c] == 0) m_busy[c] = 0;
      end
      if (cfg_we && !ob) begin
        c = cfg_ch;
        case (cfg_sel)
          3'd0: m_src[c] = cfg_wdata;
          3'd1: m_dst[c] = cfg_wdata;
          3'd2: m_cnt[c] = cfg_wdata;
          3'd3: m_str[c] = cfg_wdata;
          3'd4: begin
            m_ie[c] = cfg_wdata[1]; m_ss[c] = cfg_wdata[2]; m_ds[c] = cfg_wdata[3];
            m_sd[c] = cfg_wdata[4]; m_dd[c] = cfg_wdata[5];
            m_busy[c] = cfg_wdata[0] && (m_cnt[c] != 0);
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and monitors, away from the active edge
  logic [15:0] rd_log[$];
  int          irq_cnt[4];
  bit          req_seen;

  always @(negedge clk) begin
    if (!rst) begin
      checks += 4;
      if (bus_req !== e_req) begin
        failures++; $display("FAIL R3 bus_req=%0b expected %0b", bus_req, e_req);
      end
      if (rd_en !== e_rd_en || (e_rd_en && rd_addr !== e_rd_addr)) begin
        failures++;
        $display("FAIL R4 rd_en/rd_addr=%0b/%h expected %0b/%h", rd_en, rd_addr, e_rd_en, e_rd_addr);
      end
      if (wr_en !== e_wr_en || (e_wr_en && (wr_addr !== e_wr_addr || wr_data !== e_wr_data))) begin
        failures++;
        $display("FAIL R5 wr=%0b/%h/%h expected %0b/%h/%h", wr_en, wr_addr, wr_data,
                 e_wr_en, e_wr_addr, e_wr_data);
      end
      if (irq !== e_irq) begin
        failures++; $display("FAIL R9 irq=%b expected %b", irq, e_irq);
      end
      if (rd_en) rd_log.push_back(rd_addr);
      for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i]++;
      if (bus_req) req_seen = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch[1:0]; cfg_sel = sel[2:0]; cfg_wdata = d[15:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input int s, input int d, input int n,
                      input int st, input int ctl);
    cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, n); cfg(ch, 3, st); cfg(ch, 4, ctl);
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (3) @(negedge clk);
    while (bus_req === 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, all requirements unverified");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    req_seen = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_req && !rd_en && !wr_en && irq == 0, "R1", "outputs in reset",
        {bus_req, rd_en, wr_en, irq}, 0);
    rst = 0;
    bus_gnt = 1;

    // R9, R5: linear copy with completion pulse
    prog(0, 16'h010, 16'h100, 8, 0, 16'h03);
    wait_idle();
    for (int i = 0; i < 8; i++)
      chk(mem[16'h100 + i] == pat(16'h010 + i), "R5", "linear copy word",
          mem[16'h100 + i], pat(16'h010 + i));
    chk(irq_cnt[0] == 1, "R9", "completion pulses ch0", irq_cnt[0], 1);

    // R2: programmed but not started
    req_seen = 0; rd_log.delete();
    prog(1, 16'h020, 16'h180, 5, 3, 16'h24);
    repeat (6) @(negedge clk);
    chk(!req_seen && rd_log.size() == 0, "R2", "no request without start",
        {req_seen, 8'(rd_log.size())}, 0);
    // R6: source stride up, destination downward
    cfg(1, 4, 16'h25);
    wait_idle();
    for (int i = 0; i < 5; i++)
      chk(mem[16'h180 - i] == pat(16'h020 + 3 * i), "R6", "strided copy word",
          mem[16'h180 - i], pat(16'h020 + 3 * i));
    chk(irq_cnt[1] == 0, "R9", "no pulse when disabled", irq_cnt[1], 0);

    // R7: irregular grant across a long block
    prog(2, 16'h040, 16'h200, 20, 0, 16'h01);
    for (int k = 0; k < 90; k++) begin
      @(negedge clk);
      bus_gnt = (k % 5 != 0) && (k % 7 != 3);
    end
    bus_gnt = 1;
    wait_idle();
    for (int i = 0; i < 20; i++)
      chk(mem[16'h200 + i] == pat(16'h040 + i), "R7", "resumed copy word",
          mem[16'h200 + i], pat(16'h040 + i));

    // R8: priority between two channels armed with no grant
    bus_gnt = 0;
    prog(3, 16'h060, 16'h280, 6, 0, 16'h01);
    prog(1, 16'h070, 16'h2C0, 4, 0, 16'h01);
    repeat (4) @(negedge clk);
    rd_log.delete();
    bus_gnt = 1;
    wait_idle();
    chk(rd_log.size() == 10 && rd_log[0] == 16'h070, "R8", "lower channel first",
        rd_log[0], 16'h070);
    chk(rd_log[4] == 16'h060, "R8", "higher channel after", rd_log[4], 16'h060);

    // R8, R7: higher channel armed during a revocation takes over
    rd_log.delete();
    prog(3, 16'h300, 16'h340, 12, 0, 16'h03);
    while (rd_log.size() < 3) @(negedge clk);
    bus_gnt = 0;
    prog(0, 16'h380, 16'h3C0, 3, 0, 16'h01);
    repeat (3) @(negedge clk);
    rd_log.delete();
    bus_gnt = 1;
    wait_idle();
    chk(rd_log[0] == 16'h380, "R8", "preempting channel first", rd_log[0], 16'h380);
    for (int i = 0; i < 12; i++)
      chk(mem[16'h340 + i] == pat(16'h300 + i), "R7", "interrupted block word",
          mem[16'h340 + i], pat(16'h300 + i));
    chk(irq_cnt[3] == 1, "R9", "completion pulses ch3", irq_cnt[3], 1);

    // R10: start with zero count
    req_seen = 0;
    prog(2, 16'h3F0, 16'h3E0, 0, 0, 16'h03);
    repeat (6) @(negedge clk);
    chk(!req_seen && irq_cnt[2] == 0, "R10", "zero count start ignored", req_seen, 0);

    // R10: writes to a pending channel ignored
    bus_gnt = 0;
    prog(0, 16'h0A0, 16'h0E0, 10, 0, 16'h01);
    cfg(0, 0, 16'h3F0);
    cfg(0, 2, 2);
    rd_log.delete();
    bus_gnt = 1;
    wait_idle();
    chk(rd_log.size() == 10 && rd_log[0] == 16'h0A0, "R10", "busy channel writes ignored",
        rd_log[0], 16'h0A0);
    for (int i = 0; i < 10; i++)
      chk(mem[16'h0E0 + i] == pat(16'h0A0 + i), "R10", "busy channel copy word",
          mem[16'h0E0 + i], pat(16'h0A0 + i));

    // R6: address wrap
    rd_log.delete();
    prog(2, 16'hFFFE, 16'h3A0, 4, 0, 16'h01);
    wait_idle();
    chk(rd_log.size() == 4 && rd_log[2] == 16'h0000, "R6", "source wraps", rd_log[2], 0);
    chk(mem[16'h3A0] == pat(16'h3FE) && mem[16'h3A2] == pat(0), "R6", "wrapped data",
        mem[16'h3A2], pat(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule